// File: doc/BRIEF.md
# SDRAM Bank-State Command Sequencer

This block turns single memory requests into SDRAM command sequences. Each request gives a direction (read or write), a bank, a row and a column, and is offered with a valid/ready handshake. The block remembers which row is open in each of the four banks. A request to a row that is already open goes straight to a READ or WRITE. A request to a closed bank first gets an ACTIVE. A request to a different row of an open bank first gets a PRECHARGE of that bank and then an ACTIVE. Rows opened in other banks stay open.

A periodic timer raises a refresh demand. Once the current command spacing has run out, this demand wins over any waiting request. The block then issues a precharge of all banks and, one precharge time later, an AUTO-REFRESH. It treats every bank as closed afterwards. The minimum spacing after each command is held by one down-counter, which is loaded from the timing parameters `T_RCD`, `T_RP` and `T_RFC`. Only NOPs appear on the command pins until the counter runs out.

All command and address pins are registered, so a command appears on the pins one clock after the cycle in which it is chosen. A request is accepted (`req_ready` high) in the cycle its READ or WRITE is chosen. A request that needs PRECHARGE or ACTIVE first stays waiting on the port until then.

Top module: `sdram_cmd_seq`

## Requirements
- R1: An access to a bank with no open row produces ACTIVE (CS,RAS,CAS,WE = 0,0,1,1) with the row on `sd_addr` and the bank on `sd_ba`, and the READ or WRITE follows exactly `T_RCD` cycles later.
- R2: READ is 0,1,0,1 and WRITE is 0,1,0,0 on CS,RAS,CAS,WE. The column is on `sd_addr[COL_W-1:0]`, address bit 10 is low, and the bank is on `sd_ba`.
- R3: An access to the row already open in its bank produces only the READ or WRITE, with no ACTIVE and no PRECHARGE.
- R4: Opening a row in one bank leaves the open rows of the other banks untouched, so a later hit in those banks needs no ACTIVE.
- R5: An access to a different row of an open bank produces PRECHARGE (0,0,1,0) for that bank with address bit 10 low. ACTIVE for the new row follows exactly `T_RP` cycles later, and the access follows `T_RCD` cycles after that.
- R6: AUTO-REFRESH (0,0,0,1) is issued once for every refresh interval. With no traffic, consecutive AUTO-REFRESH commands are exactly `T_REFI` cycles apart.
- R7: Each AUTO-REFRESH is directly preceded by a PRECHARGE (0,0,1,0) with address bit 10 high, exactly `T_RP` cycles earlier.
- R8: After AUTO-REFRESH no other command is issued for `T_RFC` cycles, and requests are held off. A request waiting during the refresh gets its first command exactly `T_RFC` cycles after the AUTO-REFRESH.
- R9: After a refresh every bank counts as closed, so an access to a row that was open before it starts with ACTIVE.
- R10: While reset is asserted and after it is released, the pins carry NOP (0,1,1,1) and `req_ready` is low until a request can be served.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ROW_W | Row, column or precharge-all flag (bit 10) |
| sd_ba | output | BANK_W | Bank select |

## Verification
The bench logs every non-NOP command with its cycle number and checks exact spacings. A design that swapped `T_RP` and `T_RCD`, or issued early, shows up as a wrong gap. It sends a hit after activity in another bank. A table that cleared every bank on each ACTIVE would then add a spurious ACTIVE. It also sends a row miss, where a design that skipped the PRECHARGE would open a second row in the same bank. It places a request exactly at the start of a refresh, and after a refresh re-targets a row that had been open. A design that dropped the precharge-all, released requests before `T_RFC`, or kept stale open-row state would issue READ without ACTIVE or issue commands too early.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // Command code packed as {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010,
    CMD_REF = 4'b0001
  } sdram_cmd_e;

  typedef enum logic {
    ST_RUN     = 1'b0,
    ST_REF_PRE = 1'b1
  } seq_state_e;

endpackage

// File: rtl/sdram_delay_ctr.sv
module sdram_delay_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (cnt_q != '0);

  AST_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) load |-> !busy) else $error("command spacing violated"); // R8

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int REFI = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic pending
);

  localparam int W = $clog2(REFI) + 1;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         pend_q;
  logic         pend_d;
  logic         tick;

  assign tick = (cnt_q == '0);

  always_comb begin
    cnt_d  = tick ? W'(REFI - 1) : cnt_q - 1'b1;
    pend_d = pend_q;
    if (tick) begin
      pend_d = 1'b1;
    end else if (ack) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= W'(REFI - 1);
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pending = pend_q;

  AST_PENDING_HELD: assert property (@(posedge clk) disable iff (!rst_n) (pending && !ack) |=> pending) else $error("refresh demand lost"); // R6

endmodule

// File: rtl/sdram_bank_table.sv
module sdram_bank_table #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_en,
  input  logic              close_en,
  input  logic              close_all,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  row,
  output logic              is_open,
  output logic              row_hit
);

  localparam int NB = 1 << BANK_W;

  logic [NB-1:0]    open_vec;
  logic [ROW_W-1:0] row_tab [NB];

  for (genvar gi = 0; gi < NB; gi++) begin : g_bank
    logic             sel;
    logic             open_r;
    logic             open_d;
    logic [ROW_W-1:0] row_r;
    logic             row_en;

    assign sel    = (bank == BANK_W'(gi));
    assign row_en = sel && open_en;

    always_comb begin
      open_d = open_r;
      if (close_all) begin
        open_d = 1'b0;
      end else if (sel && close_en) begin
        open_d = 1'b0;
      end else if (row_en) begin
        open_d = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_r <= 1'b0;
        row_r  <= '0;
      end else begin
        open_r <= open_d;
        if (row_en) begin
          row_r <= row;
        end
      end
    end

    assign open_vec[gi] = open_r;
    assign row_tab[gi]  = row_r;
  end

  assign is_open = open_vec[bank];
  assign row_hit = is_open && (row_tab[bank] == row);

  AST_OPEN_ONLY_CLOSED: assert property (@(posedge clk) disable iff (!rst_n) open_en |-> !is_open) else $error("ACTIVE to a bank with an open row"); // R5
  AST_ALL_CLOSED_AFTER_PALL: assert property (@(posedge clk) disable iff (!rst_n) close_all |=> (open_vec == '0)) else $error("bank left open after precharge-all"); // R9

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 3,
  parameter int T_RFC  = 10,
  parameter int T_REFI = 1560
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ROW_W-1:0]  sd_addr,
  output logic [BANK_W-1:0] sd_ba
);

  localparam int MAX_T  = (T_RFC > T_RP) ? ((T_RFC > T_RCD) ? T_RFC : T_RCD)
                                         : ((T_RP > T_RCD) ? T_RP : T_RCD);
  localparam int CNT_W  = $clog2(MAX_T + 1);
  localparam int AP_BIT = 10;

  // Reset: asserted asynchronously, released through two flops
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  seq_state_e        state_q, state_d;
  sdram_cmd_e        cmd_q, cmd_d;
  logic [ROW_W-1:0]  addr_q, addr_d;
  logic [BANK_W-1:0] ba_q, ba_d;
  logic              pall_last_q, pall_last_d;

  logic             busy;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             ref_pend;
  logic             ref_ack;
  logic             open_en;
  logic             close_en;
  logic             close_all;
  logic             is_open;
  logic             row_hit;

  sdram_delay_ctr #(.CNT_W(CNT_W)) u_delay (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (load),
    .load_val (load_val),
    .busy     (busy)
  );

  sdram_refresh_timer #(.REFI(T_REFI)) u_refresh (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ack     (ref_ack),
    .pending (ref_pend)
  );

  sdram_bank_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_banks (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .open_en   (open_en),
    .close_en  (close_en),
    .close_all (close_all),
    .bank      (req_bank),
    .row       (req_row),
    .is_open   (is_open),
    .row_hit   (row_hit)
  );

  // Next command selection
  always_comb begin
    state_d   = state_q;
    cmd_d     = CMD_NOP;
    addr_d    = '0;
    ba_d      = '0;
    load      = 1'b0;
    load_val  = '0;
    ref_ack   = 1'b0;
    open_en   = 1'b0;
    close_en  = 1'b0;
    close_all = 1'b0;
    req_ready = 1'b0;
    if (!busy) begin
      if (state_q == ST_REF_PRE) begin
        cmd_d    = CMD_REF;
        load     = 1'b1;
        load_val = CNT_W'(T_RFC - 1);
        ref_ack  = 1'b1;
        state_d  = ST_RUN;
      end else if (ref_pend) begin
        cmd_d          = CMD_PRE;
        addr_d[AP_BIT] = 1'b1;
        load           = 1'b1;
        load_val       = CNT_W'(T_RP - 1);
        close_all      = 1'b1;
        state_d        = ST_REF_PRE;
      end else if (req_valid) begin
        ba_d = req_bank;
        if (row_hit) begin
          cmd_d              = req_write ? CMD_WR : CMD_RD;
          addr_d[COL_W-1:0]  = req_col;
          req_ready          = 1'b1;
        end else if (is_open) begin
          cmd_d    = CMD_PRE;
          load     = 1'b1;
          load_val = CNT_W'(T_RP - 1);
          close_en = 1'b1;
        end else begin
          cmd_d    = CMD_ACT;
          addr_d   = req_row;
          load     = 1'b1;
          load_val = CNT_W'(T_RCD - 1);
          open_en  = 1'b1;
        end
      end
    end
  end

  always_comb begin
    pall_last_d = pall_last_q;
    if (cmd_d != CMD_NOP) begin
      pall_last_d = (cmd_d == CMD_PRE) && addr_d[AP_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q     <= ST_RUN;
      cmd_q       <= CMD_NOP;
      addr_q      <= '0;
      ba_q        <= '0;
      pall_last_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      cmd_q       <= cmd_d;
      addr_q      <= addr_d;
      ba_q        <= ba_d;
      pall_last_q <= pall_last_d;
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_addr = addr_q;
  assign sd_ba   = ba_q;

  AST_RW_ROW_OPEN: assert property (@(posedge clk) disable iff (!rst_sync_n) ((cmd_d == CMD_RD) || (cmd_d == CMD_WR)) |-> row_hit) else $error("access to a row that is not open"); // R1
  AST_REF_AFTER_PALL: assert property (@(posedge clk) disable iff (!rst_sync_n) (cmd_d == CMD_REF) |-> pall_last_q) else $error("refresh without precharge-all"); // R7
  AST_READY_NO_REFRESH: assert property (@(posedge clk) disable iff (!rst_sync_n) req_ready |-> (!ref_pend && (state_q == ST_RUN) && !busy)) else $error("request accepted during refresh"); // R8
  AST_NOP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_n) busy |-> (cmd_d == CMD_NOP)) else $error("command inside spacing window"); // R8

endmodule

// File: tb/sdram_cmd_seq_tb.sv
`timescale 1ns/1ps
module sdram_cmd_seq_tb;

  localparam int BANK_W = 2;
  localparam int ROW_W  = 13;
  localparam int COL_W  = 10;
  localparam int T_RCD  = 3;
  localparam int T_RP   = 4;
  localparam int T_RFC  = 8;
  localparam int T_REFI = 300;
  localparam int LOG_N  = 1024;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic              req_write;
  logic [BANK_W-1:0] req_bank;
  logic [ROW_W-1:0]  req_row;
  logic [COL_W-1:0]  req_col;
  logic              sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [ROW_W-1:0]  sd_addr;
  logic [BANK_W-1:0] sd_ba;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  sdram_cmd_seq #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .T_REFI(T_REFI)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .sd_ba(sd_ba)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Command log, sampled at the falling edge
  int               cyc = 0;
  logic [3:0]       lg_cmd  [LOG_N];
  logic [ROW_W-1:0] lg_addr [LOG_N];
  logic [BANK_W-1:0] lg_ba  [LOG_N];
  int               lg_cyc  [LOG_N];
  int               lg_n = 0;
  int               ref_cnt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} != C_NOP) && lg_n < LOG_N) begin
      lg_cmd[lg_n]  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      lg_addr[lg_n] = sd_addr;
      lg_ba[lg_n]   = sd_ba;
      lg_cyc[lg_n]  = cyc;
      if (lg_cmd[lg_n] == C_REF) ref_cnt++;
      lg_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input bit wr, input int bank, input int row, input int col);
    bit got;
    @(negedge clk);
    req_write = wr;
    req_bank  = BANK_W'(bank);
    req_row   = ROW_W'(row);
    req_col   = COL_W'(col);
    req_valid = 1'b1;
    forever begin
      #1;
      got = req_ready;
      @(posedge clk);
      if (got) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sync_refresh();
    int r0;
    r0 = ref_cnt;
    while (ref_cnt == r0) @(negedge clk);
    idle(T_RFC + 2);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_bank = '0; req_row = '0; req_col = '0;
    idle(3);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R10", "pins in reset", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
    chk(req_ready == 1'b0, "R10", "ready in reset", req_ready, 0);
    rst_n = 1'b1;
    idle(5);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R10", "pins after reset", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
    chk(req_ready == 1'b0, "R10", "ready with no request", req_ready, 0);
  endtask

  // R1/R2: closed bank -> ACTIVE then READ
  task automatic t_closed_bank();
    int i;
    sync_refresh();
    i = lg_n;
    send(1'b0, 0, 5, 7);
    idle(10);
    chk(lg_n - i == 2, "R1", "command count", lg_n - i, 2);
    chk(lg_cmd[i] == C_ACT, "R1", "first cmd ACTIVE", lg_cmd[i], C_ACT);
    chk(lg_addr[i] == 5 && lg_ba[i] == 0, "R1", "ACTIVE row", lg_addr[i], 5);
    chk(lg_cmd[i+1] == C_RD, "R2", "READ code", lg_cmd[i+1], C_RD);
    chk(lg_addr[i+1] == 7 && lg_ba[i+1] == 0, "R2", "READ column", lg_addr[i+1], 7);
    chk(lg_cyc[i+1] - lg_cyc[i] == T_RCD, "R1", "ACTIVE to READ gap", lg_cyc[i+1] - lg_cyc[i], T_RCD);
  endtask

  // R3: hits produce only the access; WRITE encoding (R2)
  task automatic t_row_hit();
    int i;
    i = lg_n;
    send(1'b0, 0, 5, 9);
    idle(6);
    chk(lg_n - i == 1, "R3", "hit command count", lg_n - i, 1);
    chk(lg_cmd[i] == C_RD && lg_addr[i] == 9, "R3", "hit READ column", lg_addr[i], 9);
    i = lg_n;
    send(1'b1, 0, 5, 10);
    idle(6);
    chk(lg_n - i == 1, "R3", "hit write count", lg_n - i, 1);
    chk(lg_cmd[i] == C_WR, "R2", "WRITE code", lg_cmd[i], C_WR);
    chk(lg_addr[i] == 10 && lg_addr[i][10] == 1'b0, "R2", "WRITE column, A10 low", lg_addr[i], 10);
  endtask

  // R4: other bank opened, first bank still open
  task automatic t_other_bank();
    int i;
    i = lg_n;
    send(1'b0, 2, 100, 1);
    idle(8);
    chk(lg_n - i == 2 && lg_cmd[i] == C_ACT && lg_ba[i] == 2, "R4", "ACTIVE bank 2", lg_ba[i], 2);
    chk(lg_addr[i] == 100, "R4", "ACTIVE row bank 2", lg_addr[i], 100);
    i = lg_n;
    send(1'b1, 0, 5, 3);
    idle(6);
    chk(lg_n - i == 1, "R4", "bank 0 still open", lg_n - i, 1);
    chk(lg_cmd[i] == C_WR && lg_ba[i] == 0 && lg_addr[i] == 3, "R4", "WRITE bank 0", lg_cmd[i], C_WR);
  endtask

  // R5: row miss -> PRECHARGE, ACTIVE, READ
  task automatic t_row_miss();
    int i;
    i = lg_n;
    send(1'b0, 0, 6, 4);
    idle(10);
    chk(lg_n - i == 3, "R5", "miss command count", lg_n - i, 3);
    chk(lg_cmd[i] == C_PRE && lg_ba[i] == 0, "R5", "PRECHARGE bank 0", lg_cmd[i], C_PRE);
    chk(lg_addr[i][10] == 1'b0, "R5", "single-bank A10", lg_addr[i][10], 0);
    chk(lg_cmd[i+1] == C_ACT && lg_addr[i+1] == 6, "R5", "ACTIVE new row", lg_addr[i+1], 6);
    chk(lg_cyc[i+1] - lg_cyc[i] == T_RP, "R5", "PRE to ACT gap", lg_cyc[i+1] - lg_cyc[i], T_RP);
    chk(lg_cmd[i+2] == C_RD && lg_cyc[i+2] - lg_cyc[i+1] == T_RCD, "R5", "ACT to READ gap", lg_cyc[i+2] - lg_cyc[i+1], T_RCD);
  endtask

  function automatic int last_ref();
    for (int k = lg_n - 1; k >= 0; k--) if (lg_cmd[k] == C_REF) return k;
    return -1;
  endfunction

  // R6/R7/R9: refresh sequence, interval and closed banks afterwards
  task automatic t_refresh();
    int k1, k2, i;
    sync_refresh();
    k1 = last_ref();
    chk(k1 > 0 && lg_cmd[k1-1] == C_PRE && lg_addr[k1-1][10] == 1'b1, "R7", "PRECHARGE-ALL before REF", lg_cmd[k1-1], C_PRE);
    chk(lg_cyc[k1] - lg_cyc[k1-1] == T_RP, "R7", "PALL to REF gap", lg_cyc[k1] - lg_cyc[k1-1], T_RP);
    sync_refresh();
    k2 = last_ref();
    chk(lg_cyc[k2] - lg_cyc[k1] == T_REFI, "R6", "refresh interval", lg_cyc[k2] - lg_cyc[k1], T_REFI);
    chk(k2 - k1 == 2, "R6", "idle refresh commands", k2 - k1, 2);
    i = lg_n;
    send(1'b0, 0, 6, 2);
    idle(8);
    chk(lg_n - i == 2 && lg_cmd[i] == C_ACT, "R9", "ACTIVE after refresh", lg_cmd[i], C_ACT);
  endtask

  // R8: request waiting across a refresh
  task automatic t_refresh_stall();
    int i;
    forever begin
      @(negedge clk);
      if (lg_n > 0 && lg_cmd[lg_n-1] == C_PRE && lg_addr[lg_n-1][10]) break;
    end
    i = lg_n;
    send(1'b0, 1, 7, 0);
    idle(8);
    chk(lg_cmd[i] == C_REF, "R8", "REF first", lg_cmd[i], C_REF);
    chk(lg_cmd[i+1] == C_ACT && lg_ba[i+1] == 1, "R8", "ACTIVE after refresh", lg_cmd[i+1], C_ACT);
    chk(lg_cyc[i+1] - lg_cyc[i] == T_RFC, "R8", "REF to next gap", lg_cyc[i+1] - lg_cyc[i], T_RFC);
  endtask

  // R7: every logged refresh preceded by precharge-all
  task automatic t_log_scan();
    int bad, seen;
    bad = 0; seen = 0;
    for (int k = 0; k < lg_n; k++) begin
      if (lg_cmd[k] == C_REF) begin
        seen++;
        if (k == 0) bad++;
        else if (!(lg_cmd[k-1] == C_PRE && lg_addr[k-1][10] && lg_cyc[k] - lg_cyc[k-1] == T_RP)) bad++;
      end
    end
    chk(seen >= 4, "R6", "refresh count", seen, 4);
    chk(bad == 0, "R7", "refreshes without PALL", bad, 0);
  endtask

  initial begin
    t_reset();
    t_closed_bank();
    t_row_hit();
    t_other_bank();
    t_row_miss();
    t_refresh();
    t_refresh_stall();
    t_log_scan();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule